// File: doc/BRIEF.md
# Extended External-Data Address Generator

This block builds the 24-bit address used by an 8-bit CPU when it moves data to or from its external-data space. Four byte-wide extension registers sit on a small special-function register port. When the CPU issues a move-external request, the block combines the active 16-bit data pointer, or an 8-bit indirect register, with the matching extension bytes. The result is a full 24-bit address.

The composed address is then decoded against a sparse region map. One select line is driven for on-chip SRAM, one for the debug controller window, one for the flash error-correction byte window and one for the external memory window. An address that lands in none of these raises an unmapped flag.

Requests enter on a valid/ready handshake. Results leave one cycle later on a second valid/ready handshake. The output stage holds one result. While that result is waiting and the consumer holds `addr_ready` low, `req_ready` stays low and the result is held steady. A request is taken on any edge where `req_valid` and `req_ready` are both high. The extension registers take part only in these requests. Register traffic on its own never produces an output.

Top module: `xdata_addr_gen`

## Requirements
- R1: After reset, all four extension slots read back 0x00 and `addr_valid` is low.
- R2: A write with `cfg_wr_en` high stores `cfg_wdata` into the slot chosen by `cfg_sel`, and the new value is visible from the next cycle. The slot map is: 0 = pointer-0 extension, 1 = pointer-1 extension, 2 = indirect high byte, 3 = indirect middle byte. `cfg_rdata` shows the selected slot combinationally while `cfg_rd_en` is high, and shows 0x00 otherwise.
- R3: With `req_src` = 0, the address is {slot 0, `ptr0`}, and the values on `ptr1` and `ind_reg` have no effect.
- R4: With `req_src` = 1, the address is {slot 1, `ptr1`}.
- R5: With `req_src` = 2 or 3, the address is {slot 2, slot 3, `ind_reg`}.
- R6: At most one bit of `region_sel` is high. Bit 0 is high exactly for addresses 0x000000 to 0x001FFF (SRAM).
- R7: Bit 1 of `region_sel` marks 0x010000 to 0x01FFFF (debug). Bit 2 marks 0x080000 to 0x081FFF (error-correction bytes). Bit 3 marks 0x800000 to 0xFFFFFF (external memory).
- R8: For any address outside those four ranges, `unmapped` is high and `region_sel` is zero. Inside a range, `unmapped` is low.
- R9: A slot write in the same cycle as an accepted request does not change that request's address. It applies to later requests.
- R10: `addr_valid` rises on the edge after a request is accepted. With no accepted request it stays low, and slot writes alone never raise it.
- R11: While `addr_valid` is high and `addr_ready` is low, `addr`, `region_sel` and `unmapped` hold steady and `req_ready` is low. A new request is accepted on the edge where the held result is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Extension slot write strobe |
| cfg_rd_en | input | 1 | Extension slot read enable |
| cfg_sel | input | 2 | Slot index |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data |
| req_valid | input | 1 | Move-external request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_src | input | 2 | Pointer source: 0 pointer 0, 1 pointer 1, 2 or 3 indirect |
| ptr0 | input | 16 | Data pointer 0 value |
| ptr1 | input | 16 | Data pointer 1 value |
| ind_reg | input | 8 | Selected indirect register value |
| addr_valid | output | 1 | Result valid |
| addr_ready | input | 1 | Consumer ready for result |
| addr | output | 24 | Composed address |
| region_sel | output | 4 | One-hot region select |
| unmapped | output | 1 | Address hit no region |

## Verification
The bench builds the block with its default widths: 8-bit extension slots, 16-bit pointers and the four-region map. At these values every region edge is exact and easy to reach. The bench steps each boundary by one address on both sides, for example 0x001FFF against 0x002000 and 0x7FFFFF against 0x800000, using the indirect mode. That mode lets every byte of the address be set directly from the slots. With the default single-entry output stage, one held result is enough to exercise back-pressure and the accept-on-consume path.

// File: rtl/xa_pkg.sv
package xa_pkg;
  localparam int ADDR_W   = 24;
  localparam int PTR_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int N_SLOT   = 4;
  localparam int N_REGION = 4;

  typedef enum logic [1:0] {
    SRC_PTR0    = 2'd0,
    SRC_PTR1    = 2'd1,
    SRC_IND     = 2'd2,
    SRC_IND_ALT = 2'd3
  } src_e;

  localparam int SLOT_EXT0 = 0;
  localparam int SLOT_EXT1 = 1;
  localparam int SLOT_HI   = 2;
  localparam int SLOT_MID  = 3;

  // Regions are power-of-two sized and aligned: base and log2 of size.
  function automatic logic [ADDR_W-1:0] region_base(int idx);
    case (idx)
      0:       return 24'h000000;
      1:       return 24'h010000;
      2:       return 24'h080000;
      default: return 24'h800000;
    endcase
  endfunction

  function automatic int region_lg(int idx);
    case (idx)
      0:       return 13;
      1:       return 16;
      2:       return 13;
      default: return 23;
    endcase
  endfunction
endpackage

// File: rtl/xa_ext_regs.sv
module xa_ext_regs #(
  parameter int BW    = 8,
  parameter int NSLOT = 4,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [SW-1:0]            sel,
  input  logic [BW-1:0]            wdata,
  output logic [BW-1:0]            rdata,
  output logic [NSLOT-1:0][BW-1:0] slots_o
);
  logic [NSLOT-1:0][BW-1:0] slot_q;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[k] <= '0;
      else if (wr_en && (sel == SW'(k)))
        slot_q[k] <= wdata;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SW'(k)) |=> (slots_o[k] == $past(wdata))); // R2
  end

  assign slots_o = slot_q;
  assign rdata   = rd_en ? slot_q[sel] : '0;
endmodule

// File: rtl/xa_compose.sv
module xa_compose #(
  parameter int BW    = 8,
  parameter int PW    = 16,
  parameter int NSLOT = 4,
  localparam int AW   = BW + PW
) (
  input  logic [1:0]               src,
  input  logic [PW-1:0]            ptr0,
  input  logic [PW-1:0]            ptr1,
  input  logic [BW-1:0]            ind,
  input  logic [NSLOT-1:0][BW-1:0] slots,
  output logic [AW-1:0]            addr
);
  import xa_pkg::*;

  always_comb begin
    case (src_e'(src))
      SRC_PTR0: addr = {slots[SLOT_EXT0], ptr0};
      SRC_PTR1: addr = {slots[SLOT_EXT1], ptr1};
      default:  addr = {slots[SLOT_HI], slots[SLOT_MID], ind};
    endcase
  end
endmodule

// File: rtl/xa_region_dec.sv
module xa_region_dec #(
  parameter int AW   = 24,
  parameter int NREG = 4
) (
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] sel,
  output logic            miss
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int          LG   = xa_pkg::region_lg(i);
    localparam logic [AW-1:0] BASE = AW'(xa_pkg::region_base(i));
    assign sel[i] = ((addr >> LG) == (BASE >> LG));
  end

  assign miss = ~|sel;
endmodule

// File: rtl/xdata_addr_gen.sv
module xdata_addr_gen #(
  parameter int BW    = xa_pkg::BYTE_W,
  parameter int PW    = xa_pkg::PTR_W,
  parameter int NSLOT = xa_pkg::N_SLOT,
  parameter int NREG  = xa_pkg::N_REGION,
  localparam int AW   = BW + PW,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_en,
  input  logic            cfg_rd_en,
  input  logic [SW-1:0]   cfg_sel,
  input  logic [BW-1:0]   cfg_wdata,
  output logic [BW-1:0]   cfg_rdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_src,
  input  logic [PW-1:0]   ptr0,
  input  logic [PW-1:0]   ptr1,
  input  logic [BW-1:0]   ind_reg,
  output logic            addr_valid,
  input  logic            addr_ready,
  output logic [AW-1:0]   addr,
  output logic [NREG-1:0] region_sel,
  output logic            unmapped
);
  logic [NSLOT-1:0][BW-1:0] slots;
  logic [AW-1:0]            addr_c;
  logic [NREG-1:0]          sel_c;
  logic                     miss_c;
  logic                     accept;

  xa_ext_regs #(.BW(BW), .NSLOT(NSLOT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .rd_en(cfg_rd_en),
    .sel(cfg_sel), .wdata(cfg_wdata), .rdata(cfg_rdata), .slots_o(slots)
  );

  xa_compose #(.BW(BW), .PW(PW), .NSLOT(NSLOT)) u_comp (
    .src(req_src), .ptr0(ptr0), .ptr1(ptr1), .ind(ind_reg),
    .slots(slots), .addr(addr_c)
  );

  xa_region_dec #(.AW(AW), .NREG(NREG)) u_dec (
    .addr(addr_c), .sel(sel_c), .miss(miss_c)
  );

  assign req_ready = !addr_valid || addr_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr       <= '0;
      region_sel <= '0;
      unmapped   <= 1'b0;
    end else if (accept) begin
      addr_valid <= 1'b1;
      addr       <= addr_c;
      region_sel <= sel_c;
      unmapped   <= miss_c;
    end else if (addr_ready) begin
      addr_valid <= 1'b0;
    end
  end

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> addr_valid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && (!addr_valid || addr_ready)) |=> !addr_valid); // R10
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr) && $stable(region_sel) && $stable(unmapped))); // R11
  AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> $onehot0(region_sel)); // R6
  AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && unmapped) |-> (region_sel == '0)); // R8
  AST_EXT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && region_sel[NREG-1]) |-> addr[AW-1]); // R7
endmodule

// File: tb/xdata_addr_gen_tb.sv
`timescale 1ns/1ps
module xdata_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_src = '0;
  logic [15:0] ptr0 = '0, ptr1 = '0;
  logic [7:0]  ind_reg = '0;
  logic        addr_valid, addr_ready = 1'b1;
  logic [23:0] addr;
  logic [3:0]  region_sel;
  logic        unmapped;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  xdata_addr_gen dut_i (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_sel(logic [23:0] a);
    if (a <= 24'h001FFF) return 4'b0001;
    if (a >= 24'h010000 && a <= 24'h01FFFF) return 4'b0010;
    if (a >= 24'h080000 && a <= 24'h081FFF) return 4'b0100;
    if (a >= 24'h800000) return 4'b1000;
    return 4'b0000;
  endfunction

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic req(logic [1:0] s, logic [15:0] p0, logic [15:0] p1, logic [7:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_src = s; ptr0 = p0; ptr1 = p1; ind_reg = r;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    cfg_rd_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cfg_sel = 2'(k); #0.1;
      check("R1 slot reset", cfg_rdata, 8'h00);
    end
    cfg_rd_en = 1'b0;
    check("R1 valid low", addr_valid, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v[4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    for (int k = 0; k < 4; k++) wr(2'(k), v[k]);
    cfg_rd_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cfg_sel = 2'(k); #0.1;
      check("R2 readback", cfg_rdata, v[k]);
    end
    cfg_rd_en = 1'b0; #0.1;
    check("R2 rdata gated", cfg_rdata, 8'h00);
  endtask

  task automatic t_modes();
    req(2'd0, 16'h1234, 16'hFFFF, 8'h77);
    check("R3 ptr0 addr", addr, 24'hA11234);
    check("R10 valid after accept", addr_valid, 1);
    req(2'd1, 16'hEEEE, 16'h5678, 8'h77);
    check("R4 ptr1 addr", addr, 24'hB25678);
    req(2'd2, 16'h1111, 16'h2222, 8'h9A);
    check("R5 ind addr", addr, 24'hC3D49A);
    req(2'd3, 16'h1111, 16'h2222, 8'h05);
    check("R5 ind alt addr", addr, 24'hC3D405);
  endtask

  task automatic t_regions();
    logic [23:0] pts[14] = '{24'h000000, 24'h001FFF, 24'h002000, 24'h00FFFF,
                             24'h010000, 24'h01FFFF, 24'h020000, 24'h07FFFF,
                             24'h080000, 24'h081FFF, 24'h082000, 24'h7FFFFF,
                             24'h800000, 24'hFFFFFF};
    foreach (pts[i]) begin
      wr(2'd2, pts[i][23:16]);
      wr(2'd3, pts[i][15:8]);
      req(2'd2, 16'h0, 16'h0, pts[i][7:0]);
      check("R5 region addr", addr, pts[i]);
      if (pts[i] <= 24'h001FFF) check("R6 sram sel", region_sel, exp_sel(pts[i]));
      else check("R7 region sel", region_sel, exp_sel(pts[i]));
      check("R8 unmapped flag", unmapped, exp_sel(pts[i]) == 4'b0);
    end
  endtask

  task automatic t_same_cycle();
    wr(2'd0, 8'h11);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'h22;
    req_valid = 1'b1; req_src = 2'd0; ptr0 = 16'h4321;
    @(negedge clk);
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    check("R9 old ext used", addr, 24'h114321);
    req(2'd0, 16'h4321, 16'h0, 8'h0);
    check("R9 new ext later", addr, 24'h224321);
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R10 valid drops", addr_valid, 0);
    for (int k = 0; k < 4; k++) begin
      wr(2'(k), 8'h5A);
      check("R10 no output from writes", addr_valid, 0);
    end
  endtask

  task automatic t_backpressure();
    wr(2'd1, 8'h33);
    @(negedge clk);
    addr_ready = 1'b0;
    req_valid = 1'b1; req_src = 2'd1; ptr1 = 16'hAAAA;
    @(negedge clk);
    ptr1 = 16'hBBBB;
    check("R11 ready low", req_ready, 0);
    @(negedge clk);
    check("R11 held addr", addr, 24'h33AAAA);
    check("R11 held valid", addr_valid, 1);
    addr_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 next accepted", addr, 24'h33BBBB);
    check("R11 next valid", addr_valid, 1);
    @(negedge clk);
    check("R11 drained", addr_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_modes();
    t_regions();
    t_same_cycle();
    t_idle();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule